// File: doc/BRIEF.md
# Fault Status Capture and Serial Readout

This block collects the fault picture of a 24-channel RGB LED driver (red, green and blue, eight outputs per colour) and sends it out serially on request. Per-channel open-LED and shorted-LED results from two detector sets are taken in at the end of every PWM cycle. Each capture overwrites the previous one. The adjacent-pin-short result for each channel is taken in whenever that check completes. Device-level error conditions are latched sticky flags: over-temperature, pre-temperature warning, shorted reference resistor and open reference resistor. The two self-test outcomes are also latched, each as a redundant 3-bit pass/fail code.

A load strobe copies the whole status picture into a 288-bit shift register. Each rising edge of the serial clock then moves one bit out, most significant bit first. A clear-error strobe drops the latched device flags and self-test codes. A synchronous reset returns everything to its power-on state. The serial clock is sampled in the system clock domain, and its rising edges are detected there. While the enable input is low, the shift register ignores both the load strobe and serial clock edges.

Top module: `fault_status_shift`

## Requirements
- R1: After reset, and again after any later synchronous reset, every field reads as zero. This includes the per-channel data, the sticky flags, both negate bits and both 3-bit code fields.
- R2: The 288-bit image holds the following per-channel data. Bits 287..264 are open-set-2 and bits 263..240 are open-set-1. Bits 239..216 are the adjacent-short channel bits. Bits 191..168 are short-set-2 and bits 167..144 are short-set-1. Within each 24-bit group, the input vector bit c maps to group bit c, where c = colour*8 + channel and the colours are red=0, green=1, blue=2.
- R3: The four per-channel open/short sets are captured from their raw inputs on every PWM-cycle strobe. Each capture overwrites the old values, and the clear-error strobe does not change them.
- R4: Bit 205 (set 1) and bit 204 (set 2) are negate bits. Each one inverts on every PWM-cycle capture.
- R5: Bit 215 (over-temperature), bit 214 (pre-temperature warning), bit 210 (reference short) and bit 209 (reference open) are sticky. Each flag becomes 1 in the cycle after its raw input is high, and stays 1 until a clear-error strobe.
- R6: If a raw fault input is high in the same cycle as the clear-error strobe, its flag stays set.
- R7: Bits 213..211 hold the adjacent-short check code and bits 208..206 hold the detector self-test code. In both fields, 000b means not yet tested, 011b means pass and 110b means fail.
  - A done pulse loads 110b if the fail input is high and 011b otherwise.
  - A fail code stays in place against a later pass unless a clear-error strobe arrives in the same cycle.
  - A clear-error strobe without a done pulse sets the code to 000b.
  - The adjacent-check done pulse also captures the 24 adjacent-short channel bits.
- R8: After a load, the serial output shows bit 287. Each detected rising serial-clock edge presents the next lower bit, and zeros enter at bit 0.
- R9: While enable is low, the load strobe and serial-clock edges leave the shift register unchanged. The status capture itself continues.
- R10: Bits 203..192 and 143..0 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows loading and shifting of the shift register |
| sclkIn | input | 1 | Serial clock, rising edges detected in the clk domain |
| loadStrobe | input | 1 | Copies the status image into the shift register |
| clearErr | input | 1 | Clears the sticky flags and code fields |
| pwmCycleEnd | input | 1 | End-of-PWM-cycle strobe; captures the per-channel sets |
| openSet1 | input | 24 | Raw open-LED results, detector set 1 |
| openSet2 | input | 24 | Raw open-LED results, detector set 2 |
| shortSet1 | input | 24 | Raw shorted-LED results, detector set 1 |
| shortSet2 | input | 24 | Raw shorted-LED results, detector set 2 |
| adjShortChan | input | 24 | Raw adjacent-pin-short result per channel |
| adjCheckDone | input | 1 | Adjacent-short check finished (pulse) |
| adjCheckFail | input | 1 | Adjacent-short check outcome, valid with done |
| selfTestDone | input | 1 | Detector self-test finished (pulse) |
| selfTestFail | input | 1 | Self-test outcome, valid with done |
| overTemp | input | 1 | Raw over-temperature condition |
| preTempWarn | input | 1 | Raw pre-temperature warning |
| refShort | input | 1 | Raw reference resistor short |
| refOpen | input | 1 | Raw reference resistor open |
| serOut | output | 1 | Serial status data, MSB first |

## Verification
The hardest situations to reach are the collisions:
- a clear-error strobe in the same cycle as a live fault;
- a clear-error strobe in the same cycle as a self-test done pulse;
- a fail code followed by a later pass.

The stimulus produces each of these by raising both inputs at one falling edge, then reading the whole image back through 288 serial clocks. The other hard case is loading with enable low while new PWM data arrive. Here the bench loads and reads one bit, lowers enable, then changes the data and pulses load and the serial clock. It then raises enable and shifts out the rest without reloading, which must give the old image. A fresh load afterwards must show that the capture went on.

// File: rtl/fss_pkg.sv
package fss_pkg;

  localparam int COLORS        = 3;
  localparam int CH_PER_COLOR  = 8;
  localparam int CH            = COLORS * CH_PER_COLOR;
  localparam int RSV_LO_W      = 144;
  localparam int RSV_HI_W      = 12;
  localparam int FLAG_N        = 4;
  localparam int CODE_W        = 3;
  localparam int SR_W          = 2 * CH + CH + FLAG_N + 2 * CODE_W + 2 + RSV_HI_W + 2 * CH + RSV_LO_W;

  localparam int SHORT1_LSB    = RSV_LO_W;
  localparam int SHORT2_LSB    = SHORT1_LSB + CH;
  localparam int NEG2_POS      = SHORT2_LSB + CH + RSV_HI_W;
  localparam int NEG1_POS      = NEG2_POS + 1;
  localparam int ST_CODE_LSB   = NEG1_POS + 1;
  localparam int REF_OPEN_POS  = ST_CODE_LSB + CODE_W;
  localparam int REF_SHORT_POS = REF_OPEN_POS + 1;
  localparam int ADJ_CODE_LSB  = REF_SHORT_POS + 1;
  localparam int PRE_TEMP_POS  = ADJ_CODE_LSB + CODE_W;
  localparam int OVER_TEMP_POS = PRE_TEMP_POS + 1;
  localparam int ADJ_CHAN_LSB  = OVER_TEMP_POS + 1;
  localparam int OPEN1_LSB     = ADJ_CHAN_LSB + CH;
  localparam int OPEN2_LSB     = OPEN1_LSB + CH;

  localparam logic [CODE_W-1:0] CODE_NONE = 3'b000;
  localparam logic [CODE_W-1:0] CODE_PASS = 3'b011;
  localparam logic [CODE_W-1:0] CODE_FAIL = 3'b110;

  typedef struct packed {
    logic load;
    logic shift;
    logic clearFlags;
    logic capture;
  } fss_strobe_t;

endpackage

// File: rtl/fss_code_field.sv
module fss_code_field
  import fss_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              done,
  input  logic              fail,
  output logic [CODE_W-1:0] code
);

  logic [CODE_W-1:0] codeNext;

  always_comb begin
    codeNext = code;
    if (done) begin
      if (fail) begin
        codeNext = CODE_FAIL;
      end else if ((code == CODE_FAIL) && !clear) begin
        codeNext = CODE_FAIL;
      end else begin
        codeNext = CODE_PASS;
      end
    end else if (clear) begin
      codeNext = CODE_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= CODE_NONE;
    end else begin
      code <= codeNext;
    end
  end

endmodule

// File: rtl/fss_ctrl.sv
module fss_ctrl
  import fss_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        sclkIn,
  input  logic        loadStrobe,
  input  logic        clearErr,
  input  logic        pwmCycleEnd,
  output fss_strobe_t strb
);

  logic sclkQ;
  logic sclkRise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkQ <= 1'b0;
    end else begin
      sclkQ <= sclkIn;
    end
  end

  assign sclkRise = sclkIn & ~sclkQ;

  always_comb begin
    strb.load       = loadStrobe & enable;
    strb.shift      = sclkRise & enable;
    strb.clearFlags = clearErr;
    strb.capture    = pwmCycleEnd;
  end

endmodule

// File: rtl/fss_datapath.sv
module fss_datapath
  import fss_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  fss_strobe_t     strb,
  input  logic [CH-1:0]   openSet1,
  input  logic [CH-1:0]   openSet2,
  input  logic [CH-1:0]   shortSet1,
  input  logic [CH-1:0]   shortSet2,
  input  logic [CH-1:0]   adjShortChan,
  input  logic            adjCheckDone,
  input  logic            adjCheckFail,
  input  logic            selfTestDone,
  input  logic            selfTestFail,
  input  logic            overTemp,
  input  logic            preTempWarn,
  input  logic            refShort,
  input  logic            refOpen,
  output logic [SR_W-1:0] statusImage,
  output logic [SR_W-1:0] shiftReg
);

  localparam int SETS = 4;

  logic [SETS-1:0][CH-1:0] setRaw;
  logic [SETS-1:0][CH-1:0] setQ;
  logic [CH-1:0]           adjChanQ;
  logic                    neg1Q;
  logic                    neg2Q;
  logic [FLAG_N-1:0]       flagRaw;
  logic [FLAG_N-1:0]       flagQ;
  logic [CODE_W-1:0]       adjCode;
  logic [CODE_W-1:0]       stCode;

  // Set order: 0 open1, 1 open2, 2 short1, 3 short2
  assign setRaw[0] = openSet1;
  assign setRaw[1] = openSet2;
  assign setRaw[2] = shortSet1;
  assign setRaw[3] = shortSet2;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst) begin
        setQ[s] <= '0;
      end else if (strb.capture) begin
        setQ[s] <= setRaw[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      neg1Q <= 1'b0;
      neg2Q <= 1'b0;
    end else if (strb.capture) begin
      neg1Q <= ~neg1Q;
      neg2Q <= ~neg2Q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      adjChanQ <= '0;
    end else if (adjCheckDone) begin
      adjChanQ <= adjShortChan;
    end
  end

  // Flag order: 3 over-temp, 2 pre-temp, 1 ref short, 0 ref open
  assign flagRaw = {overTemp, preTempWarn, refShort, refOpen};

  for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flagQ[f] <= 1'b0;
      end else if (flagRaw[f]) begin
        flagQ[f] <= 1'b1;
      end else if (strb.clearFlags) begin
        flagQ[f] <= 1'b0;
      end
    end
  end

  fss_code_field u_adjCode (
    .clk   (clk),
    .rst   (rst),
    .clear (strb.clearFlags),
    .done  (adjCheckDone),
    .fail  (adjCheckFail),
    .code  (adjCode)
  );

  fss_code_field u_stCode (
    .clk   (clk),
    .rst   (rst),
    .clear (strb.clearFlags),
    .done  (selfTestDone),
    .fail  (selfTestFail),
    .code  (stCode)
  );

  always_comb begin
    statusImage = '0;
    statusImage[OPEN2_LSB +: CH]        = setQ[1];
    statusImage[OPEN1_LSB +: CH]        = setQ[0];
    statusImage[ADJ_CHAN_LSB +: CH]     = adjChanQ;
    statusImage[OVER_TEMP_POS]          = flagQ[3];
    statusImage[PRE_TEMP_POS]           = flagQ[2];
    statusImage[ADJ_CODE_LSB +: CODE_W] = adjCode;
    statusImage[REF_SHORT_POS]          = flagQ[1];
    statusImage[REF_OPEN_POS]           = flagQ[0];
    statusImage[ST_CODE_LSB +: CODE_W]  = stCode;
    statusImage[NEG1_POS]               = neg1Q;
    statusImage[NEG2_POS]               = neg2Q;
    statusImage[SHORT2_LSB +: CH]       = setQ[3];
    statusImage[SHORT1_LSB +: CH]       = setQ[2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strb.load) begin
      shiftReg <= statusImage;
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[SR_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/fault_status_shift.sv
module fault_status_shift
  import fss_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          sclkIn,
  input  logic          loadStrobe,
  input  logic          clearErr,
  input  logic          pwmCycleEnd,
  input  logic [CH-1:0] openSet1,
  input  logic [CH-1:0] openSet2,
  input  logic [CH-1:0] shortSet1,
  input  logic [CH-1:0] shortSet2,
  input  logic [CH-1:0] adjShortChan,
  input  logic          adjCheckDone,
  input  logic          adjCheckFail,
  input  logic          selfTestDone,
  input  logic          selfTestFail,
  input  logic          overTemp,
  input  logic          preTempWarn,
  input  logic          refShort,
  input  logic          refOpen,
  output logic          serOut
);

  fss_strobe_t     strb;
  logic [SR_W-1:0] statusImage;
  logic [SR_W-1:0] shiftReg;

  fss_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .sclkIn      (sclkIn),
    .loadStrobe  (loadStrobe),
    .clearErr    (clearErr),
    .pwmCycleEnd (pwmCycleEnd),
    .strb        (strb)
  );

  fss_datapath u_dp (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .openSet1     (openSet1),
    .openSet2     (openSet2),
    .shortSet1    (shortSet1),
    .shortSet2    (shortSet2),
    .adjShortChan (adjShortChan),
    .adjCheckDone (adjCheckDone),
    .adjCheckFail (adjCheckFail),
    .selfTestDone (selfTestDone),
    .selfTestFail (selfTestFail),
    .overTemp     (overTemp),
    .preTempWarn  (preTempWarn),
    .refShort     (refShort),
    .refOpen      (refOpen),
    .statusImage  (statusImage),
    .shiftReg     (shiftReg)
  );

  assign serOut = shiftReg[SR_W-1];

endmodule

// File: rtl/fss_checker.sv
module fss_checker
  import fss_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            enable,
  input logic            clearErr,
  input logic            overTemp,
  input logic            pwmCycleEnd,
  input logic            strbLoad,
  input logic            strbShift,
  input logic [SR_W-1:0] statusImage,
  input logic [SR_W-1:0] shiftReg,
  input logic            serOut
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (shiftReg == '0 && statusImage == '0)); // R1

  AST_LOAD_IMAGE: assert property (@(posedge clk) disable iff (rst) strbLoad |=> (shiftReg == $past(statusImage))); // R8

  AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (rst) (strbShift && !strbLoad) |=> (serOut == $past(shiftReg[SR_W-2]))); // R8

  AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst) (strbShift && !strbLoad) |=> !shiftReg[0]); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !enable |=> $stable(shiftReg)); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (statusImage[OVER_TEMP_POS] && !clearErr) |=> statusImage[OVER_TEMP_POS]); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) (overTemp && clearErr) |=> statusImage[OVER_TEMP_POS]); // R6

  AST_NEG_TOGGLE: assert property (@(posedge clk) disable iff (rst) pwmCycleEnd |=> (statusImage[NEG1_POS] != $past(statusImage[NEG1_POS]))); // R4

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst) (statusImage[ADJ_CODE_LSB +: CODE_W] == CODE_NONE || statusImage[ADJ_CODE_LSB +: CODE_W] == CODE_PASS || statusImage[ADJ_CODE_LSB +: CODE_W] == CODE_FAIL)); // R7

endmodule

bind fault_status_shift fss_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .clearErr    (clearErr),
  .overTemp    (overTemp),
  .pwmCycleEnd (pwmCycleEnd),
  .strbLoad    (strb.load),
  .strbShift   (strb.shift),
  .statusImage (statusImage),
  .shiftReg    (shiftReg),
  .serOut      (serOut)
);

// File: tb/test_fault_status_shift.sv
module test_fault_status_shift;

  localparam int CLK_PERIOD = 10;
  localparam int W = 288;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1;
  logic sclkIn = 1'b0;
  logic loadStrobe = 1'b0;
  logic clearErr = 1'b0;
  logic pwmCycleEnd = 1'b0;
  logic [23:0] openSet1 = '0, openSet2 = '0, shortSet1 = '0, shortSet2 = '0, adjShortChan = '0;
  logic adjCheckDone = 1'b0, adjCheckFail = 1'b0, selfTestDone = 1'b0, selfTestFail = 1'b0;
  logic overTemp = 1'b0, preTempWarn = 1'b0, refShort = 1'b0, refOpen = 1'b0;
  logic serOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Expected state, kept from the requirements
  logic [23:0] eOpen1, eOpen2, eShort1, eShort2, eAdj;
  logic eOt, ePt, eRs, eRo, eNeg1, eNeg2;
  logic [2:0] eAdjCode, eStCode;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_status_shift i_fault_status_shift (
    .clk(clk), .rst(rst), .enable(enable), .sclkIn(sclkIn), .loadStrobe(loadStrobe),
    .clearErr(clearErr), .pwmCycleEnd(pwmCycleEnd), .openSet1(openSet1), .openSet2(openSet2),
    .shortSet1(shortSet1), .shortSet2(shortSet2), .adjShortChan(adjShortChan),
    .adjCheckDone(adjCheckDone), .adjCheckFail(adjCheckFail), .selfTestDone(selfTestDone),
    .selfTestFail(selfTestFail), .overTemp(overTemp), .preTempWarn(preTempWarn),
    .refShort(refShort), .refOpen(refOpen), .serOut(serOut)
  );

  task automatic modelReset();
    eOpen1 = '0; eOpen2 = '0; eShort1 = '0; eShort2 = '0; eAdj = '0;
    eOt = 0; ePt = 0; eRs = 0; eRo = 0; eNeg1 = 0; eNeg2 = 0;
    eAdjCode = 3'b000; eStCode = 3'b000;
  endtask

  function automatic logic [W-1:0] expImage();
    logic [W-1:0] img;
    img = '0;
    img[287:264] = eOpen2;
    img[263:240] = eOpen1;
    img[239:216] = eAdj;
    img[215] = eOt;
    img[214] = ePt;
    img[213:211] = eAdjCode;
    img[210] = eRs;
    img[209] = eRo;
    img[208:206] = eStCode;
    img[205] = eNeg1;
    img[204] = eNeg2;
    img[191:168] = eShort2;
    img[167:144] = eShort1;
    return img;
  endfunction

  task automatic check1(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic readImage(bit doLoad, output logic [W-1:0] img);
    if (doLoad) begin
      loadStrobe = 1'b1;
      tick();
      loadStrobe = 1'b0;
    end
    for (int i = W - 1; i >= 0; i--) begin
      img[i] = serOut;
      sclkIn = 1'b1;
      tick();
      sclkIn = 1'b0;
      tick();
    end
  endtask

  task automatic pwmPulse();
    pwmCycleEnd = 1'b1;
    tick();
    pwmCycleEnd = 1'b0;
    eOpen1 = openSet1; eOpen2 = openSet2; eShort1 = shortSet1; eShort2 = shortSet2;
    eNeg1 = ~eNeg1; eNeg2 = ~eNeg2;
  endtask

  task automatic testReset();
    logic [W-1:0] img;
    modelReset();
    readImage(1, img);
    check1("R1 reset image", img, '0);
    check1("R10 reserved zero", {img[203:192], img[143:0]}, '0);
    check1("R8 zero fill after full shift", {{(W-1){1'b0}}, serOut}, '0);
  endtask

  task automatic testChannelData();
    logic [W-1:0] img;
    openSet1 = 24'hA5_3C_81; openSet2 = 24'h80_0F_01;
    shortSet1 = 24'h12_34_56; shortSet2 = 24'hFE_DC_BA;
    pwmPulse();
    readImage(1, img);
    check1("R2 per-channel layout", img, expImage());
    check1("R4 negate bits after one capture", {{(W-2){1'b0}}, img[205], img[204]}, {{(W-2){1'b0}}, 2'b11});
    check1("R8 zero fill after nonzero image", {{(W-1){1'b0}}, serOut}, '0);
  endtask

  task automatic testRefresh();
    logic [W-1:0] img;
    openSet1 = 24'h00_00_01; openSet2 = 24'h00_10_00;
    shortSet1 = 24'h40_00_00; shortSet2 = 24'h00_00_00;
    pwmPulse();
    clearErr = 1'b1;
    tick();
    clearErr = 1'b0;
    readImage(1, img);
    check1("R3 overwrite and clear immunity", img, expImage());
    check1("R4 negate bits after second capture", {{(W-2){1'b0}}, img[205], img[204]}, '0);
  endtask

  task automatic testStickyFlags();
    logic [W-1:0] img;
    overTemp = 1'b1; tick(); overTemp = 1'b0;
    tick();
    refOpen = 1'b1; tick(); refOpen = 1'b0;
    preTempWarn = 1'b1; refShort = 1'b1; tick(); preTempWarn = 1'b0; refShort = 1'b0;
    eOt = 1; ePt = 1; eRs = 1; eRo = 1;
    tick();
    readImage(1, img);
    check1("R5 flags latched after pulses", img, expImage());
    clearErr = 1'b1; tick(); clearErr = 1'b0;
    eOt = 0; ePt = 0; eRs = 0; eRo = 0;
    readImage(1, img);
    check1("R5 flags cleared", img, expImage());
  endtask

  task automatic testSetWins();
    logic [W-1:0] img;
    overTemp = 1'b1; refOpen = 1'b1; clearErr = 1'b1;
    tick();
    overTemp = 1'b0; refOpen = 1'b0; clearErr = 1'b0;
    eOt = 1; eRo = 1;
    readImage(1, img);
    check1("R6 set beats clear", img, expImage());
    clearErr = 1'b1; tick(); clearErr = 1'b0;
    eOt = 0; eRo = 0;
    readImage(1, img);
    check1("R6 later clear drops flags", img, expImage());
  endtask

  task automatic testCodes();
    logic [W-1:0] img;
    adjShortChan = 24'hC0_01_3E;
    adjCheckDone = 1'b1; adjCheckFail = 1'b0;
    selfTestDone = 1'b1; selfTestFail = 1'b1;
    tick();
    adjCheckDone = 1'b0; selfTestDone = 1'b0; selfTestFail = 1'b0;
    eAdj = 24'hC0_01_3E; eAdjCode = 3'b011; eStCode = 3'b110;
    readImage(1, img);
    check1("R7 pass and fail codes", img, expImage());
    selfTestDone = 1'b1; selfTestFail = 1'b0; tick(); selfTestDone = 1'b0;
    adjCheckDone = 1'b1; adjCheckFail = 1'b1; tick();
    adjCheckFail = 1'b0; tick(); adjCheckDone = 1'b0;
    eAdjCode = 3'b110;
    readImage(1, img);
    check1("R7 fail code survives later pass", img, expImage());
    clearErr = 1'b1; tick(); clearErr = 1'b0;
    eAdjCode = 3'b000; eStCode = 3'b000;
    readImage(1, img);
    check1("R7 clear returns codes to untested", img, expImage());
    adjShortChan = 24'h00_00_80;
    clearErr = 1'b1; selfTestDone = 1'b1; selfTestFail = 1'b1;
    adjCheckDone = 1'b1; adjCheckFail = 1'b0;
    tick();
    clearErr = 1'b0; selfTestDone = 1'b0; selfTestFail = 1'b0; adjCheckDone = 1'b0;
    eAdj = 24'h00_00_80; eStCode = 3'b110; eAdjCode = 3'b011;
    readImage(1, img);
    check1("R7 done together with clear", img, expImage());
  endtask

  task automatic testEnable();
    logic [W-1:0] imgA;
    logic [W-1:0] img;
    logic firstBit;
    openSet2 = 24'hFF_FF_FF;
    pwmPulse();
    imgA = expImage();
    loadStrobe = 1'b1; tick(); loadStrobe = 1'b0;
    firstBit = serOut;
    enable = 1'b0;
    openSet2 = 24'h00_00_00; openSet1 = 24'h0F_0F_0F;
    pwmPulse();
    loadStrobe = 1'b1; tick(); loadStrobe = 1'b0;
    for (int k = 0; k < 3; k++) begin
      sclkIn = 1'b1; tick(); sclkIn = 1'b0; tick();
    end
    check1("R9 output held while disabled", {{(W-1){1'b0}}, serOut}, {{(W-1){1'b0}}, firstBit});
    enable = 1'b1;
    tick();
    readImage(0, img);
    check1("R9 disabled load and shifts ignored", img, imgA);
    readImage(1, img);
    check1("R9 capture continues while disabled", img, expImage());
  endtask

  task automatic testGlobalReset();
    logic [W-1:0] img;
    overTemp = 1'b1; selfTestDone = 1'b1; tick();
    overTemp = 1'b0; selfTestDone = 1'b0;
    rst = 1'b1; tick(); rst = 1'b0;
    modelReset();
    tick();
    readImage(1, img);
    check1("R1 synchronous reset clears all", img, '0);
  endtask

  initial begin
    modelReset();
    tick(); tick();
    rst = 1'b0;
    tick();
    testReset();
    testChannelData();
    testRefresh();
    testStickyFlags();
    testSetWins();
    testCodes();
    testEnable();
    testGlobalReset();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule